// File: doc/BRIEF.md
# Carry-aware radix-4 Booth recoder

This block produces the radix-4 Booth select lines for a 16-bit signed multiplier operand that arrives in partial carry-save form. The operand is a 16-bit sum word plus one saved carry bit for each 4-bit fragment above the lowest, and its binary value is never formed. The true carry entering each fragment comes from a short chain built from per-fragment generate and propagate terms. The tuple bits that a carry can change are worked out from those carries and the sum word.

Each digit is recoded twice, in parallel. The first encoder is the ordinary one. The second assumes that a one has been added at the tuple's middle position. A per-digit control bit, which is the true carry into that position, picks the correct result. The three select lines of each digit then go to the multiple generator of a multiplier. The block is purely combinational.

Top module: `booth_pcs_recoder`

## Requirements
- R1: With an all-zero sum word and no saved carries, every neg, one and two line is 0.
- R2: The carry into fragment f+1 is the saved carry for that fragment, OR'd with the carry into fragment f when fragment f of the sum word is all ones. Such a carry can ripple across several fragments, and the digits reflect it.
- R3: Each digit is shown on three lines: neg (negative), one (magnitude 1) and two (magnitude 2). No digit ever drives one and two together. A zero digit drives all three lines to 0.
- R4: Let y be the true binary value (sum word plus saved carries, modulo 2^16), with y[-1] taken as 0. Digit p (0..7) equals -2*y[2p+1] + y[2p] + y[2p-1].
- R5: The sum over p of digit_p * 4^p equals y read as a signed 16-bit number.
- R6: When no saved carry is set, the digits equal the plain radix-4 recoding of the sum word alone.
- R7: Saved-carry input bit j adds 2^(4(j+1)), at the lowest bit of fragment j+1. Operands are legal only if that bit is set while fragment j of the sum word is not all ones.
- R8: A carry out of the top fragment is dropped, so y wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mul_sum_i | input | 16 | Sum word of the redundant multiplier |
| mul_cry_i | input | 3 | Saved carries; bit j enters fragment j+1 at bit 4(j+1) |
| dig_neg_o | output | 8 | Per-digit negative select |
| dig_one_o | output | 8 | Per-digit magnitude-1 select |
| dig_two_o | output | 8 | Per-digit magnitude-2 select |

## Verification
Assertions check several relations whenever the inputs change. They confirm that the select lines stay well formed, and that the weighted digit sum matches the signed value rebuilt from both input words. They confirm that a carry-free operand gives the plain recoding of the sum word. They also confirm that every saved carry is legal. Only the bench scenarios can show that each digit sits in the right position with the expected value. This includes the carry chains that ripple across several all-ones fragments and the wrap past the top fragment. The bench covers these with directed operands and with random and carry-heavy streams, checked against a reference recoding of the rebuilt integer.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    localparam int unsigned RCD_WIDTH = 16;
    localparam int unsigned RCD_FRAG  = 4;

    // One Booth digit in select-line form
    typedef struct packed {
        logic neg;
        logic one;
        logic two;
    } bsel_t;

    // Ordinary recoding of {hi, mid, lo}
    function automatic bsel_t enc_plain(input logic [2:0] t);
        bsel_t r;
        r = '0;
        case (t)
            3'b001, 3'b010: r.one = 1'b1;
            3'b011:         r.two = 1'b1;
            3'b100: begin r.two = 1'b1; r.neg = 1'b1; end
            3'b101, 3'b110: begin r.one = 1'b1; r.neg = 1'b1; end
            default:        r = '0;
        endcase
        return r;
    endfunction

    // Recoding of {hi, mid, lo} with a one added at the mid position.
    // The carry out of hi is dropped, because the next digit's control absorbs it.
    function automatic bsel_t enc_plus1(input logic [2:0] t);
        bsel_t r;
        r = '0;
        case (t)
            3'b000, 3'b111: r.one = 1'b1;
            3'b001:         r.two = 1'b1;
            3'b010: begin r.two = 1'b1; r.neg = 1'b1; end
            3'b011, 3'b100: begin r.one = 1'b1; r.neg = 1'b1; end
            default:        r = '0;
        endcase
        return r;
    endfunction

    // Signed value of a digit, used by the checks
    function automatic int bsel_value(input bsel_t s);
        int m;
        m = s.two ? 2 : (s.one ? 1 : 0);
        return s.neg ? -m : m;
    endfunction

endpackage

// File: rtl/rcd_true_carry.sv
module rcd_true_carry #(
    parameter int W    = 16,
    parameter int FRAG = 4,
    localparam int NF  = W / FRAG
) (
    input  logic [W-1:0]  sum_w,
    input  logic [NF-2:0] sav_cry,
    output logic [NF-1:0] frag_cin
);

    logic [NF-2:0] grp_gen;
    logic [NF-2:0] grp_prop;

    genvar j;
    generate
        for (j = 0; j < NF - 1; j++) begin : g_frag
            assign grp_gen[j]    = sav_cry[j];
            assign grp_prop[j]   = &sum_w[j*FRAG +: FRAG];
            assign frag_cin[j+1] = grp_gen[j] | (grp_prop[j] & frag_cin[j]);
        end
    endgenerate

    assign frag_cin[0] = 1'b0;

    always_comb begin
        for (int k = 0; k < NF - 1; k++) begin
            // R7
            legal_cry_chk: assert (!(sav_cry[k] && (&sum_w[k*FRAG +: FRAG])))
                else $error("saved carry %0d set above an all-ones fragment", k);
        end
    end

endmodule

// File: rtl/rcd_tuple_gen.sv
module rcd_tuple_gen #(
    parameter int W    = 16,
    parameter int FRAG = 4,
    localparam int NF  = W / FRAG,
    localparam int ND  = W / 2
) (
    input  logic [W-1:0]        sum_w,
    input  logic [NF-1:0]       frag_cin,
    output logic [ND-1:0][2:0]  tup,
    output logic [ND-1:0]       ctrl
);

    // True carry into each bit position, which rides on the fragment carry
    logic [W-1:0] bit_cin;

    always_comb begin
        bit_cin = '0;
        for (int i = 0; i < W; i++) begin
            if ((i % FRAG) == 0) begin
                bit_cin[i] = frag_cin[i / FRAG];
            end else begin
                bit_cin[i] = bit_cin[i-1] & sum_w[i-1];
            end
        end
    end

    genvar p;
    generate
        for (p = 0; p < ND; p++) begin : g_dig
            assign ctrl[p] = bit_cin[2*p];
            if (p == 0) begin : g_first
                assign tup[p] = {sum_w[1], sum_w[0], 1'b0};
            end else begin : g_rest
                assign tup[p] = {sum_w[2*p+1], sum_w[2*p], sum_w[2*p-1] ^ bit_cin[2*p-1]};
            end
        end
    endgenerate

endmodule

// File: rtl/rcd_digit_sel.sv
module rcd_digit_sel
    import rcd_pkg::*;
#(
    parameter int ND = 8
) (
    input  logic [ND-1:0][2:0] tup,
    input  logic [ND-1:0]      ctrl,
    output bsel_t [ND-1:0]     sel
);

    genvar p;
    generate
        for (p = 0; p < ND; p++) begin : g_enc
            bsel_t plain_s;
            bsel_t adj_s;
            assign plain_s = enc_plain(tup[p]);
            assign adj_s   = enc_plus1(tup[p]);
            assign sel[p]  = ctrl[p] ? adj_s : plain_s;
        end
    endgenerate

endmodule

// File: rtl/booth_pcs_recoder.sv
module booth_pcs_recoder
    import rcd_pkg::*;
#(
    parameter int W    = RCD_WIDTH,
    parameter int FRAG = RCD_FRAG,
    localparam int NF  = W / FRAG,
    localparam int ND  = W / 2
) (
    input  logic [W-1:0]  mul_sum_i,
    input  logic [NF-2:0] mul_cry_i,
    output logic [ND-1:0] dig_neg_o,
    output logic [ND-1:0] dig_one_o,
    output logic [ND-1:0] dig_two_o
);

    logic [NF-1:0]      frag_cin;
    logic [ND-1:0][2:0] tup;
    logic [ND-1:0]      ctrl;
    bsel_t [ND-1:0]     sel;

    rcd_true_carry #(.W(W), .FRAG(FRAG)) u_carry (
        .sum_w    (mul_sum_i),
        .sav_cry  (mul_cry_i),
        .frag_cin (frag_cin)
    );

    rcd_tuple_gen #(.W(W), .FRAG(FRAG)) u_tuple (
        .sum_w    (mul_sum_i),
        .frag_cin (frag_cin),
        .tup      (tup),
        .ctrl     (ctrl)
    );

    rcd_digit_sel #(.ND(ND)) u_sel (
        .tup  (tup),
        .ctrl (ctrl),
        .sel  (sel)
    );

    always_comb begin
        for (int p = 0; p < ND; p++) begin
            dig_neg_o[p] = sel[p].neg;
            dig_one_o[p] = sel[p].one;
            dig_two_o[p] = sel[p].two;
        end
    end

    // Checks across the carry, tuple and select stages
    logic [W-1:0] chk_y;
    longint       chk_acc;

    always_comb begin
        chk_y = mul_sum_i;
        for (int j = 0; j < NF - 1; j++) begin
            chk_y = chk_y + (W'(mul_cry_i[j]) << ((j + 1) * FRAG));
        end
        chk_acc = 0;
        for (int p = 0; p < ND; p++) begin
            chk_acc = chk_acc + (longint'(bsel_value(sel[p])) <<< (2 * p));
            // R3
            sel_onehot_chk: assert (!(dig_one_o[p] && dig_two_o[p]))
                else $error("digit %0d drives one and two", p);
            // R3
            zero_neg_chk: assert (!dig_neg_o[p] || dig_one_o[p] || dig_two_o[p])
                else $error("digit %0d negative zero", p);
            // R6
            if (mul_cry_i == '0) begin
                plain_path_chk: assert (sel[p] == enc_plain({mul_sum_i[2*p+1], mul_sum_i[2*p],
                                        (p == 0) ? 1'b0 : mul_sum_i[(p == 0) ? 0 : 2*p-1]}))
                    else $error("digit %0d differs from plain recoding", p);
            end
        end
        // R5
        digit_sum_chk: assert (chk_acc == longint'($signed(chk_y)))
            else $error("weighted digits %0d differ from operand %0d", chk_acc, $signed(chk_y));
    end

endmodule

// File: tb/booth_pcs_recoder_tb_top.sv
module booth_pcs_recoder_tb_top;

    localparam int W  = 16;
    localparam int NF = 4;
    localparam int ND = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0]  v_in  = '0;
    logic [NF-2:0] c_in  = '0;
    logic [ND-1:0] d_neg, d_one, d_two;

    int errors = 0;
    int checks = 0;

    booth_pcs_recoder dut_i (
        .mul_sum_i (v_in),
        .mul_cry_i (c_in),
        .dig_neg_o (d_neg),
        .dig_one_o (d_one),
        .dig_two_o (d_two)
    );

    // Reference: rebuild the integer and recode it digit by digit
    task automatic check_vec(input logic [W-1:0] v, input logic [NF-2:0] c, input string tag);
        logic [W-1:0] y;
        logic [ND-1:0] en, eo, et;
        int yv, d, acc, dv;
        bit bad3;
        @(negedge clk);
        v_in = v;
        c_in = c;
        @(posedge clk);
        #1;
        y = v + W'({c[2], 3'b000, c[1], 3'b000, c[0], 4'b0000});
        yv = int'($signed(y));
        for (int p = 0; p < ND; p++) begin
            d = -2 * int'(y[2*p+1]) + int'(y[2*p]) + ((p == 0) ? 0 : int'(y[2*p-1]));
            en[p] = (d < 0);
            eo[p] = (d == 1) || (d == -1);
            et[p] = (d == 2) || (d == -2);
        end
        // R4 per-digit comparison
        checks++;
        if (d_neg != en || d_one != eo || d_two != et) begin
            errors++;
            $display("FAIL %s/R4 v=%h c=%b: neg/one/two act=%b/%b/%b exp=%b/%b/%b",
                     tag, v, c, d_neg, d_one, d_two, en, eo, et);
        end
        // R3 line form
        bad3 = 1'b0;
        for (int p = 0; p < ND; p++) begin
            if ((d_one[p] && d_two[p]) || (d_neg[p] && !d_one[p] && !d_two[p])) bad3 = 1'b1;
        end
        checks++;
        if (bad3) begin
            errors++;
            $display("FAIL R3 v=%h c=%b: act neg/one/two=%b/%b/%b exp well-formed", v, c, d_neg, d_one, d_two);
        end
        // R5 weighted sum
        acc = 0;
        for (int p = 0; p < ND; p++) begin
            dv = d_two[p] ? 2 : (d_one[p] ? 1 : 0);
            if (d_neg[p]) dv = -dv;
            acc = acc + dv * (1 << (2 * p));
        end
        checks++;
        if (acc != yv) begin
            errors++;
            $display("FAIL R5 v=%h c=%b: act sum=%0d exp=%0d", v, c, acc, yv);
        end
    endtask

    function automatic logic [NF-2:0] legalize(input logic [W-1:0] v, input logic [NF-2:0] c);
        logic [NF-2:0] r;
        r = c;
        for (int j = 0; j < NF - 1; j++) begin
            if (&v[j*4 +: 4]) r[j] = 1'b0;
        end
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] rv;
        logic [NF-2:0] rc;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R1 reset-like zero operand: every line low
        @(negedge clk);
        checks++;
        if (d_neg != '0 || d_one != '0 || d_two != '0) begin
            errors++;
            $display("FAIL R1: act=%b/%b/%b exp=0/0/0", d_neg, d_one, d_two);
        end
        check_vec(16'h0000, 3'b000, "R1");

        // R6 carry-free operands
        check_vec(16'h1234, 3'b000, "R6");
        check_vec(16'hFFFF, 3'b000, "R6");
        check_vec(16'h8000, 3'b000, "R6");
        check_vec(16'h5555, 3'b000, "R6");
        check_vec(16'hAAAA, 3'b000, "R6");

        // R7 saved carry positions
        check_vec(16'h00FE, 3'b001, "R7");
        check_vec(16'h0000, 3'b010, "R7");
        check_vec(16'h0000, 3'b100, "R7");
        check_vec(16'h0E0E, 3'b111, "R7");

        // R2 carry ripple through all-ones fragments
        check_vec(16'h0FF0, 3'b001, "R2");
        check_vec(16'h3FF7, 3'b001, "R2");
        check_vec(16'h1F3F, 3'b010, "R2");
        check_vec(16'h7FF0, 3'b001, "R2");

        // R8 wrap past top fragment
        check_vec(16'hFFF0, 3'b001, "R8");
        check_vec(16'hF000, 3'b100, "R8");
        check_vec(16'hFF00, 3'b010, "R8");

        // R4 random legal operands
        for (int n = 0; n < 400; n++) begin
            rv = W'($urandom);
            rc = NF'($urandom) ;
            check_vec(rv, legalize(rv, rc), "R4");
        end

        // R2 carry-heavy operands: fragments biased to all ones
        for (int n = 0; n < 300; n++) begin
            rv = W'($urandom);
            for (int j = 0; j < NF; j++) begin
                if ($urandom_range(0, 2) != 0) rv[j*4 +: 4] = 4'hF;
            end
            rc = 3'($urandom);
            rc = legalize(rv, rc);
            if (rc == '0 && !(&rv[3:0])) rc[0] = 1'b1;
            check_vec(rv, rc, "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule